// File: doc/BRIEF.md
# Interrupt Flag and Enable Unit

This block holds the interrupt flag register and the interrupt enable register of a peripheral-style controller with timers and a shift register, and combines them into a single level interrupt. Five internal event sources (shift register done, shift data, shift clock, timer 2 and timer 1) raise their flags with one-cycle pulses. Software reaches the two registers over a byte-wide bus whose register index is a 4-bit field of the address. Software clears flags in two ways: by writing ones to the flag register, or as a side effect of reading certain data registers that live elsewhere in the same register map.

The enable register is never written directly. Bit 7 of the written byte selects whether the ones in the low seven bits are set or cleared, and every other bit keeps its value. The flag register read returns a synthesized summary in bit 7, and the enable register read always shows bit 7 as one.

Top module: `irq_flag_unit`

## Requirements
- R1: After reset the flag and enable registers are both zero, `irq` is low, and a flag read returns 0x00 while an enable read returns 0x80.
- R2: A pulse on `srcSet[i]` sets flag bit i+2 on the next clock edge. The flag bits are 0x04 shift done (i=0), 0x08 shift data (i=1), 0x10 shift clock (i=2), 0x20 timer 2 (i=3) and 0x40 timer 1 (i=4).
- R3: `irq` is high exactly when flag AND enable has bit 0x04, 0x20 or 0x40 set. The shift data and shift clock flags never drive `irq`.
- R4: A read of index 0xD returns the flags in bits 6:0. Bit 7 is 1 when flag AND enable is nonzero over any bit.
- R5: A read of index 0xE returns the enables in bits 6:0, with bit 7 always 1.
- R6: A write to index 0xE with data bit 7 = 1 sets every enable bit whose data bit is 1. With bit 7 = 0 it clears every such bit. All other enable bits are unchanged.
- R7: A write to index 0xD clears every flag whose data bit is 1. Flags whose data bit is 0 are unchanged.
- R8: A read of index 0xA (shift data register) clears flags 0x04, 0x08 and 0x10.
- R9: A read of index 0x4 (timer 1 count low) clears flag 0x40. A read of index 0x8 (timer 2 count low) clears flag 0x20.
- R10: When a set pulse and a clear (by write or by read) hit the same flag in the same cycle, the flag ends up set.
- R11: Reads and writes of any other index return 0x00 on `rdData` and change neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 4 | Register index (address bits 12:9) |
| rdEn | input | 1 | Read strobe, one cycle per access |
| wrEn | input | 1 | Write strobe, one cycle per access |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data, combinational for the current index |
| srcSet | input | 5 | Flag set pulses: shift done, shift data, shift clock, timer 2, timer 1 |
| irq | output | 1 | Level interrupt request |

## Verification
On every cycle the assertions check these rules:
- a set pulse always lands, even when a clear hits the same flag in that cycle;
- no flag rises without a pulse;
- the enable register holds its value when no enable write happens;
- `irq` stays low when no interrupting source is enabled;
- an enable read always shows bit 7.

Only the bench's scenarios can show the rest, which depends on which flags and enables are present at the time:
- the exact flag value left after each clear path (flag write, shift-data read, timer count reads);
- that the summary bit and `irq` differ when only shift data or shift clock is enabled;
- that writes and reads of unrelated indices leave both registers alone.

// File: rtl/ifu_pkg.sv
package ifu_pkg;
  localparam int DATA_W = 8;
  localparam int REG_W  = DATA_W - 1;

  // Flag bit positions; sources map in this order onto bits SRC_LSB upward
  localparam int SRC_LSB = 2;
  localparam int NUM_SRC = 5;
  localparam int BIT_SHIFT = 2;
  localparam int BIT_SDATA = 3;
  localparam int BIT_SCLK  = 4;
  localparam int BIT_TMR2  = 5;
  localparam int BIT_TMR1  = 6;

  localparam logic [REG_W-1:0] IRQ_MASK =
    REG_W'((1 << BIT_SHIFT) | (1 << BIT_TMR2) | (1 << BIT_TMR1));
  localparam logic [REG_W-1:0] SHIFT_CLR_MASK =
    REG_W'((1 << BIT_SHIFT) | (1 << BIT_SDATA) | (1 << BIT_SCLK));
  localparam logic [REG_W-1:0] TMR1_CLR_MASK = REG_W'(1 << BIT_TMR1);
  localparam logic [REG_W-1:0] TMR2_CLR_MASK = REG_W'(1 << BIT_TMR2);

  // Register indices that matter to this block
  localparam int IDX_W = 4;
  localparam logic [IDX_W-1:0] IDX_FLAG  = 4'hD;
  localparam logic [IDX_W-1:0] IDX_EN    = 4'hE;
  localparam logic [IDX_W-1:0] IDX_SHIFT = 4'hA;
  localparam logic [IDX_W-1:0] IDX_T1LO  = 4'h4;
  localparam logic [IDX_W-1:0] IDX_T2LO  = 4'h8;

  typedef struct packed {
    logic flagWr;
    logic enWr;
    logic flagRd;
    logic enRd;
    logic clrShiftRd;
    logic clrT1Rd;
    logic clrT2Rd;
  } strobe_t;
endpackage

// File: rtl/ifu_decode.sv
module ifu_decode
  import ifu_pkg::*;
#(
  parameter int IW = IDX_W,
  parameter logic [IW-1:0] FLAG_IDX  = IDX_FLAG,
  parameter logic [IW-1:0] EN_IDX    = IDX_EN,
  parameter logic [IW-1:0] SHIFT_IDX = IDX_SHIFT,
  parameter logic [IW-1:0] T1LO_IDX  = IDX_T1LO,
  parameter logic [IW-1:0] T2LO_IDX  = IDX_T2LO
) (
  input  logic [IW-1:0] regIdx,
  input  logic          rdEn,
  input  logic          wrEn,
  output strobe_t       strb
);
  always_comb begin
    strb            = '0;
    strb.flagWr     = wrEn && (regIdx == FLAG_IDX);
    strb.enWr       = wrEn && (regIdx == EN_IDX);
    strb.flagRd     = rdEn && (regIdx == FLAG_IDX);
    strb.enRd       = rdEn && (regIdx == EN_IDX);
    strb.clrShiftRd = rdEn && (regIdx == SHIFT_IDX);
    strb.clrT1Rd    = rdEn && (regIdx == T1LO_IDX);
    strb.clrT2Rd    = rdEn && (regIdx == T2LO_IDX);
  end
endmodule

// File: rtl/ifu_regs.sv
module ifu_regs
  import ifu_pkg::*;
#(
  parameter int DW   = DATA_W,
  parameter int NSRC = NUM_SRC,
  parameter int SLSB = SRC_LSB,
  localparam int RW  = DW - 1
) (
  input  logic            clk,
  input  logic            rstN,
  input  strobe_t         strb,
  input  logic [DW-1:0]   wrData,
  input  logic [NSRC-1:0] srcSet,
  output logic [DW-1:0]   rdData,
  output logic            irq
);
  logic [RW-1:0] flagQ, enQ;
  logic [RW-1:0] setMask, clrMask, flagNext, enNext;

  // Map source pulses onto their flag positions
  for (genvar b = 0; b < RW; b++) begin : g_setmap
    if (b >= SLSB && b < SLSB + NSRC) begin : g_src
      assign setMask[b] = srcSet[b-SLSB];
    end else begin : g_none
      assign setMask[b] = 1'b0;
    end
  end

  always_comb begin
    clrMask = '0;
    if (strb.flagWr)     clrMask = clrMask | wrData[RW-1:0];
    if (strb.clrShiftRd) clrMask = clrMask | SHIFT_CLR_MASK;
    if (strb.clrT1Rd)    clrMask = clrMask | TMR1_CLR_MASK;
    if (strb.clrT2Rd)    clrMask = clrMask | TMR2_CLR_MASK;
    // set applied after clear: a same-cycle event wins
    flagNext = (flagQ & ~clrMask) | setMask;
  end

  always_comb begin
    enNext = enQ;
    if (strb.enWr) begin
      if (wrData[DW-1]) enNext = enQ | wrData[RW-1:0];
      else              enNext = enQ & ~wrData[RW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flagQ <= '0;
      enQ   <= '0;
    end else begin
      flagQ <= flagNext;
      enQ   <= enNext;
    end
  end

  always_comb begin
    rdData = '0;
    if (strb.flagRd)    rdData = {|(flagQ & enQ), flagQ};
    else if (strb.enRd) rdData = {1'b1, enQ};
  end

  assign irq = |(flagQ & enQ & IRQ_MASK);

  p_set_lands_r2: assert property (@(posedge clk) disable iff (!rstN)
    (|setMask) |=> ((flagQ & $past(setMask)) == $past(setMask)));

  p_set_wins_r10: assert property (@(posedge clk) disable iff (!rstN)
    (|(setMask & clrMask)) |=>
      ((flagQ & $past(setMask & clrMask)) == $past(setMask & clrMask)));

  p_no_spurious_r7: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((flagQ & ~$past(flagQ) & ~$past(setMask)) == '0));

  p_en_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.enWr) |=> (enQ == $past(enQ)));

  p_irq_needs_en_r3: assert property (@(posedge clk) disable iff (!rstN)
    ((enQ & IRQ_MASK) == '0) |-> !irq);
endmodule

// File: rtl/irq_flag_unit.sv
module irq_flag_unit
  import ifu_pkg::*;
#(
  parameter int DW   = DATA_W,
  parameter int IW   = IDX_W,
  parameter int NSRC = NUM_SRC
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [IW-1:0]   busAddr,
  input  logic            rdEn,
  input  logic            wrEn,
  input  logic [DW-1:0]   wrData,
  output logic [DW-1:0]   rdData,
  input  logic [NSRC-1:0] srcSet,
  output logic            irq
);
  strobe_t strb;

  ifu_decode #(.IW(IW)) u_decode (
    .regIdx (busAddr),
    .rdEn   (rdEn),
    .wrEn   (wrEn),
    .strb   (strb)
  );

  ifu_regs #(.DW(DW), .NSRC(NSRC)) u_regs (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .wrData (wrData),
    .srcSet (srcSet),
    .rdData (rdData),
    .irq    (irq)
  );

  p_en_read_top_r5: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && busAddr == IDX_EN) |-> rdData[DW-1]);
endmodule

// File: tb/sim_irq_flag_unit.sv
module sim_irq_flag_unit;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] busAddr = '0;
  logic       rdEn = 1'b0, wrEn = 1'b0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic [4:0] srcSet = '0;
  logic       irq;

  int checks = 0, errors = 0;
  int mFlag = 0, mEn = 0;
  logic [7:0] lastRd;
  logic       lastIrq;
  bit         done = 0;

  always #2 clk = ~clk;

  irq_flag_unit u0 (.clk(clk), .rstN(rstN), .busAddr(busAddr), .rdEn(rdEn),
    .wrEn(wrEn), .wrData(wrData), .rdData(rdData), .srcSet(srcSet), .irq(irq));

  task automatic step(input string tag, input logic r, input logic w,
                      input logic [3:0] idx, input logic [7:0] d, input logic [4:0] s);
    int expRd, expIrq, clr;
    @(negedge clk);
    rdEn = r; wrEn = w; busAddr = idx; wrData = d; srcSet = s;
    #1;
    expRd = 0;
    if (r && idx == 4'hD) expRd = (((mFlag & mEn) != 0) ? 128 : 0) | mFlag;
    else if (r && idx == 4'hE) expRd = 128 | mEn;
    expIrq = ((mFlag & mEn & 8'h64) != 0) ? 1 : 0;
    lastRd = rdData; lastIrq = irq;
    checks++;
    if (rdData !== 8'(expRd) || irq !== 1'(expIrq)) begin
      errors++;
      $display("FAIL %s model: rdData=%h irq=%b expected rdData=%h irq=%0d",
               tag, rdData, irq, expRd, expIrq);
    end
    if (!rstN) begin
      mFlag = 0; mEn = 0;
    end else begin
      clr = 0;
      if (w && idx == 4'hD) clr |= d & 127;
      if (r && idx == 4'hA) clr |= 8'h1C;
      if (r && idx == 4'h4) clr |= 8'h40;
      if (r && idx == 4'h8) clr |= 8'h20;
      mFlag = ((mFlag & ~clr) | (int'(s) << 2)) & 127;
      if (w && idx == 4'hE) begin
        if (d[7]) mEn = mEn | (d & 127);
        else      mEn = mEn & ~int'(d) & 127;
      end
    end
  endtask

  task automatic idle(input string tag);
    step(tag, 1'b0, 1'b0, 4'h0, 8'h00, 5'h00);
  endtask

  task automatic rdk(input string tag, input logic [3:0] idx, input logic [7:0] exp);
    step(tag, 1'b1, 1'b0, idx, 8'h00, 5'h00);
    checks++;
    if (lastRd !== exp) begin
      errors++;
      $display("FAIL %s read idx %h: got %h expected %h", tag, idx, lastRd, exp);
    end
  endtask

  task automatic wr(input string tag, input logic [3:0] idx, input logic [7:0] d);
    step(tag, 1'b0, 1'b1, idx, d, 5'h00);
  endtask

  task automatic irqk(input string tag, input logic exp);
    idle(tag);
    checks++;
    if (lastIrq !== exp) begin
      errors++;
      $display("FAIL %s irq: got %b expected %b", tag, lastIrq, exp);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    idle("R1"); idle("R1"); idle("R1");
    @(negedge clk); rstN = 1'b1;
    // R1 reset state
    rdk("R1", 4'hD, 8'h00);
    rdk("R1", 4'hE, 8'h80);
    irqk("R1", 1'b0);
    // R2 each source sets its own bit
    step("R2", 0, 0, 0, 0, 5'h01);
    step("R2", 0, 0, 0, 0, 5'h02);
    step("R2", 0, 0, 0, 0, 5'h04);
    step("R2", 0, 0, 0, 0, 5'h08);
    step("R2", 0, 0, 0, 0, 5'h10);
    rdk("R2", 4'hD, 8'h7C);
    irqk("R3", 1'b0);
    // R6 set-enable, R3 irq, R4 summary
    wr("R6", 4'hE, 8'h84);
    irqk("R3", 1'b1);
    rdk("R4", 4'hD, 8'hFC);
    // R7 flag write clears ones
    wr("R7", 4'hD, 8'h04);
    rdk("R7", 4'hD, 8'h78);
    irqk("R3", 1'b0);
    // shift data enabled: summary yes, irq no
    wr("R6", 4'hE, 8'h88);
    rdk("R4", 4'hD, 8'hF8);
    irqk("R3", 1'b0);
    wr("R6", 4'hE, 8'h08);
    rdk("R6", 4'hE, 8'h84);
    wr("R7", 4'hD, 8'h00);
    rdk("R7", 4'hD, 8'h78);
    // R8 shift data read clears shift flags
    rdk("R11", 4'hA, 8'h00);
    rdk("R8", 4'hD, 8'h60);
    // R9 timer count reads
    wr("R6", 4'hE, 8'hE0);
    irqk("R3", 1'b1);
    rdk("R9", 4'h4, 8'h00);
    rdk("R9", 4'hD, 8'hA0);
    irqk("R9", 1'b1);
    rdk("R9", 4'h8, 8'h00);
    rdk("R9", 4'hD, 8'h00);
    irqk("R9", 1'b0);
    // R10 set beats clear
    step("R10", 1, 0, 4'h4, 8'h00, 5'h10);
    rdk("R10", 4'hD, 8'hC0);
    step("R10", 0, 1, 4'hD, 8'h7F, 5'h01);
    rdk("R10", 4'hD, 8'h84);
    // R11 other indices
    wr("R11", 4'h3, 8'hFF);
    wr("R11", 4'hF, 8'h00);
    wr("R11", 4'h5, 8'h7F);
    rdk("R11", 4'hD, 8'h84);
    rdk("R11", 4'hE, 8'hE4);
    rdk("R11", 4'h2, 8'h00);
    // mixed traffic against the model
    lfsr = 16'hACE1;
    for (int i = 0; i < 400; i++) begin
      logic [3:0] idx;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      case (lfsr[2:0])
        3'd0, 3'd1: idx = 4'hD;
        3'd2, 3'd3: idx = 4'hE;
        3'd4: idx = 4'hA;
        3'd5: idx = 4'h4;
        3'd6: idx = 4'h8;
        default: idx = lfsr[7:4];
      endcase
      step("R6", lfsr[8], lfsr[9] & ~lfsr[8], idx, lfsr[15:8],
           (lfsr[11:10] == 2'b00) ? lfsr[14:10] : 5'h00);
    end
    idle("R3");
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule